// File: doc/BRIEF.md
# I2C Byte Shifter with Acknowledge Bit

This block is the serial data path of a byte-oriented I2C-style channel. Another unit makes the transfer clock and hands it over as one-cycle strobes, one for each rising edge and one for each falling edge. When a byte starts, the block latches a 9-bit transmit word. It drives the data line through an open-drain pull-down enable. The line is pulled low for a 0 and released for a 1. The order is the eight data bits, most significant first, then the acknowledge level held in bit 8. The block can hold the line output back by a programmable number of system clocks, and a disable input can release the line at any time.

On the same nine clocks the block samples the line on each rising edge. After the ninth sample it gives a 9-bit receive word and a one-cycle done strobe. There are two packings of the receive word. The normal one puts the acknowledge bit in bit 8. The alternate one moves the last data bit to bit 8. A clock-phase option turns the alternate packing back into the normal one for the word produced after the ninth clock. While the channel is switched off, the line's resting level can be preset and transfers cannot start.

Top module: `i2c_byte_shifter`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `sda_oe` is 0, `rx_word` is 0 and `byte_done` is 0.
- R2: A `load` pulse latches `tx_word`. The first transmitted bit is `tx_word[7]`. Each `scl_fall` moves on to the next bit in the order 7,6,...,0, and then to `tx_word[8]` (acknowledge level). The new bit shows at the line output one clock after the strobe when there is no delay.
- R3: The line output is open-drain. A level of 0 gives `sda_oe`=1 and a level of 1 gives `sda_oe`=0. With no transfer in progress the level is the stored resting level. The acknowledge bit is held until the `scl_fall` that follows the ninth `scl_rise`.
- R4: `dly_sel`=0 adds no delay. A value s in 1..7 delays every change of the line level by s+1 system clocks, so the range is 2 to 8.
- R5: `sda_off`=1 forces `sda_oe` to 0 in the same cycle, whatever the level or delay.
- R6: The resting level is copied from `idle_lvl` only while `chan_en`=0. While `chan_en`=1 it holds. A `load` while `chan_en`=0 is ignored.
- R7: `sda_in` is sampled on each `scl_rise` of a transfer. On the clock after the ninth sample, `byte_done` is 1 for exactly one cycle and `rx_word` takes its new value. `rx_word` changes at no other time.
- R8: Normal packing (`alt_pack`=0). Received bits 1..8 go to `rx_word[7:0]` with bit 1 in bit 7, and received bit 9 goes to `rx_word[8]`.
- R9: Alternate packing (`alt_pack`=1, `clk_phase`=0). Received bits 1..7 go to `rx_word[6:0]` with bit 1 in bit 6, received bit 8 goes to `rx_word[8]`, and received bit 9 goes to `rx_word[7]`.
- R10: With `alt_pack`=1 and `clk_phase`=1, the word produced after the ninth clock uses the normal packing of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; 0 allows the resting level to be preset |
| idle_lvl | input | 1 | Resting line level, copied while `chan_en`=0 |
| load | input | 1 | Start a byte and latch `tx_word` |
| tx_word | input | 9 | Bits 7..0 data, bit 8 acknowledge level |
| scl_rise | input | 1 | One-cycle strobe per rising transfer-clock edge |
| scl_fall | input | 1 | One-cycle strobe per falling transfer-clock edge |
| sda_in | input | 1 | Synchronised data line level |
| alt_pack | input | 1 | 0 normal packing, 1 alternate packing |
| clk_phase | input | 1 | With alternate packing, 1 restores the normal packing after bit 9 |
| dly_sel | input | 3 | Output delay select: 0 none, s gives s+1 clocks |
| sda_off | input | 1 | Force the line released |
| sda_oe | output | 1 | Open-drain pull-down enable |
| rx_word | output | 9 | Packed receive word |
| byte_done | output | 1 | One-cycle strobe after the ninth sample |

## Verification
Seven vectors feed received patterns against different transmit words. All-zero, all-ones-with-low-acknowledge, alternating and sparse patterns separate the three packings. A wrong bit mapping or a swap of the data bit and the acknowledge bit therefore shows up in the word. The same vectors step through transmit words with distinct top bits and acknowledge bits, which exposes order and off-by-one errors in the shift. Directed runs move the resting level under delays of 4 and 8 clocks to pin down the latency exactly. They also check the force-release control, and show that preset and load are ignored in the wrong channel state.

// File: rtl/i2cbs_pkg.sv
package i2cbs_pkg;
   typedef enum logic [0:0] {
      PACK_NORMAL = 1'b0,
      PACK_ALT    = 1'b1
   } pack_e;

   localparam int unsigned DEF_DATA_W  = 8;
   localparam int unsigned DEF_DLY_MAX = 8;
endpackage

// File: rtl/i2cbs_tx_seq.sv
module i2cbs_tx_seq #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned WORD_W = DATA_W + 1,
   localparam int unsigned IDX_W  = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_go,
   input  logic              fall_go,
   input  logic [WORD_W-1:0] tx_word,
   output logic              tx_bit
);
   logic [WORD_W-1:0] word_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  pick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '1;
         idx_q  <= '0;
      end else if (load_go) begin
         word_q <= tx_word;
         idx_q  <= '0;
      end else if (fall_go && (idx_q < IDX_W'(DATA_W))) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   // data bits MSB first, then the acknowledge bit at the top
   always_comb begin
      if (idx_q < IDX_W'(DATA_W)) pick = IDX_W'(DATA_W - 1) - idx_q;
      else                        pick = IDX_W'(DATA_W);
      tx_bit = word_q[pick];
   end
endmodule

// File: rtl/i2cbs_rx_pack.sv
module i2cbs_rx_pack
   import i2cbs_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter bit          ALT_EN = 1'b1,
   localparam int unsigned WORD_W = DATA_W + 1,
   localparam int unsigned CNT_W  = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              sample,
   input  logic              sda_in,
   input  pack_e             layout,
   input  logic              clk_phase,
   output logic              last,
   output logic [WORD_W-1:0] rx_word,
   output logic              byte_done
);
   logic [DATA_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] full;
   logic [WORD_W-1:0] norm_w;
   logic [WORD_W-1:0] pack_w;

   assign last   = sample && (cnt_q == CNT_W'(DATA_W));
   assign full   = {sh_q, sda_in};              // full[WORD_W-1] is the first bit
   assign norm_w = {full[0], full[WORD_W-1:1]};

   generate
      if (ALT_EN) begin : g_alt
         logic [WORD_W-1:0] alt_w;
         assign alt_w  = {full[1], full[0], full[WORD_W-1:2]};
         assign pack_w = (layout == PACK_ALT && !clk_phase) ? alt_w : norm_w;
      end else begin : g_norm
         assign pack_w = norm_w;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q      <= '0;
         cnt_q     <= '0;
         rx_word   <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= last;
         if (clear) begin
            cnt_q <= '0;
         end else if (sample) begin
            sh_q  <= {sh_q[DATA_W-2:0], sda_in};
            cnt_q <= last ? '0 : cnt_q + 1'b1;
         end
         if (last) rx_word <= pack_w;
      end
   end
endmodule

// File: rtl/i2cbs_sda_delay.sv
module i2cbs_sda_delay #(
   parameter int unsigned DLY_MAX = 8,
   localparam int unsigned SEL_W  = $clog2(DLY_MAX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_in,
   input  logic [SEL_W-1:0] sel,
   output logic             lvl_out
);
   logic [DLY_MAX-1:0] pipe_q;

   generate
      for (genvar g = 0; g < DLY_MAX; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pipe_q[g] <= 1'b1;
            else if (g == 0) pipe_q[g] <= lvl_in;
            else             pipe_q[g] <= pipe_q[(g == 0) ? 0 : g - 1];
         end
      end
   endgenerate

   // sel s > 0 taps stage s, which lags by s+1 clocks
   assign lvl_out = (sel == '0) ? lvl_in : pipe_q[sel];
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
   import i2cbs_pkg::*;
#(
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned DLY_MAX = DEF_DLY_MAX,
   parameter bit          ALT_EN  = 1'b1,
   localparam int unsigned WORD_W = DATA_W + 1,
   localparam int unsigned SEL_W  = $clog2(DLY_MAX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              idle_lvl,
   input  logic              load,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_in,
   input  logic              alt_pack,
   input  logic              clk_phase,
   input  logic [SEL_W-1:0]  dly_sel,
   input  logic              sda_off,
   output logic              sda_oe,
   output logic [WORD_W-1:0] rx_word,
   output logic              byte_done
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (DLY_MAX < 2 || (1 << SEL_W) != DLY_MAX) begin : g_bad_dly
         $error("DLY_MAX must be a power of two, at least 2");
      end
   endgenerate

   logic  rx_busy_q;
   logic  tx_hold_q;
   logic  idle_q;
   logic  load_go;
   logic  last;
   logic  tx_bit;
   logic  raw_lvl;
   logic  dly_lvl;
   pack_e layout;

   assign load_go = load && chan_en;
   assign layout  = pack_e'(alt_pack);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_busy_q <= 1'b0;
         tx_hold_q <= 1'b0;
         idle_q    <= 1'b1;
      end else begin
         if (!chan_en) idle_q <= idle_lvl;
         if (load_go)   rx_busy_q <= 1'b1;
         else if (last) rx_busy_q <= 1'b0;
         // keep the acknowledge bit until the falling edge after the ninth clock
         if (load_go)                     tx_hold_q <= 1'b1;
         else if (scl_fall && !rx_busy_q) tx_hold_q <= 1'b0;
      end
   end

   i2cbs_tx_seq #(.DATA_W(DATA_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_go (load_go),
      .fall_go (scl_fall && tx_hold_q),
      .tx_word (tx_word),
      .tx_bit  (tx_bit)
   );

   i2cbs_rx_pack #(.DATA_W(DATA_W), .ALT_EN(ALT_EN)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (load_go),
      .sample    (scl_rise && rx_busy_q && !load_go),
      .sda_in    (sda_in),
      .layout    (layout),
      .clk_phase (clk_phase),
      .last      (last),
      .rx_word   (rx_word),
      .byte_done (byte_done)
   );

   assign raw_lvl = tx_hold_q ? tx_bit : idle_q;

   i2cbs_sda_delay #(.DLY_MAX(DLY_MAX)) u_dly (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_in  (raw_lvl),
      .sel     (dly_sel),
      .lvl_out (dly_lvl)
   );

   assign sda_oe = !sda_off && !dly_lvl;
endmodule

// File: rtl/i2cbs_checker.sv
module i2cbs_checker #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_rise,
   input logic              sda_in,
   input logic              alt_pack,
   input logic              clk_phase,
   input logic              sda_off,
   input logic              sda_oe,
   input logic [DATA_W:0]   rx_word,
   input logic              byte_done
);
   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !byte_done);

   p_done_after_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |-> $past(scl_rise));

   p_rx_only_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_word != $past(rx_word)) |-> byte_done);

   p_off_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sda_off |-> !sda_oe);

   p_ack_bit8_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !$past(alt_pack)) |-> (rx_word[DATA_W] == $past(sda_in)));

   p_ack_bit7_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && $past(alt_pack) && !$past(clk_phase))
         |-> (rx_word[DATA_W-1] == $past(sda_in)));

   p_ack_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && $past(alt_pack) && $past(clk_phase))
         |-> (rx_word[DATA_W] == $past(sda_in)));
endmodule

bind i2c_byte_shifter i2cbs_checker #(.DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_rise  (scl_rise),
   .sda_in    (sda_in),
   .alt_pack  (alt_pack),
   .clk_phase (clk_phase),
   .sda_off   (sda_off),
   .sda_oe    (sda_oe),
   .rx_word   (rx_word),
   .byte_done (byte_done)
);

// File: tb/i2c_byte_shifter_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_shifter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chan_en = 1'b1;
   logic       idle_lvl = 1'b1;
   logic       load = 1'b0;
   logic [8:0] tx_word = '0;
   logic       scl_rise = 1'b0;
   logic       scl_fall = 1'b0;
   logic       sda_in = 1'b1;
   logic       alt_pack = 1'b0;
   logic       clk_phase = 1'b0;
   logic [2:0] dly_sel = '0;
   logic       sda_off = 1'b0;
   logic       sda_oe;
   logic [8:0] rx_word;
   logic       byte_done;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   i2c_byte_shifter dut_i (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .idle_lvl(idle_lvl),
      .load(load), .tx_word(tx_word), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_in(sda_in), .alt_pack(alt_pack), .clk_phase(clk_phase),
      .dly_sel(dly_sel), .sda_off(sda_off), .sda_oe(sda_oe),
      .rx_word(rx_word), .byte_done(byte_done)
   );

   // {tx_word[8:0], pattern bit1..bit9 (MSB first), alt, phase, expected rx[8:0]}
   localparam logic [28:0] VEC [0:6] = '{
      {9'h0A5, 9'b101001011, 1'b0, 1'b0, 9'h1A5},
      {9'h15A, 9'b101001011, 1'b1, 1'b0, 9'h1D2},
      {9'h1FF, 9'b101001011, 1'b1, 1'b1, 9'h1A5},
      {9'h000, 9'b000000000, 1'b0, 1'b0, 9'h000},
      {9'h13C, 9'b111111110, 1'b1, 1'b0, 9'h17F},
      {9'h0C3, 9'b011000010, 1'b0, 1'b0, 9'h061},
      {9'h101, 9'b011000010, 1'b1, 1'b0, 9'h130}
   };

   task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse_rise();
      @(negedge clk) scl_rise = 1'b1;
      @(negedge clk) scl_rise = 1'b0;
   endtask

   task automatic pulse_fall();
      @(negedge clk) scl_fall = 1'b1;
      @(negedge clk) scl_fall = 1'b0;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL R7 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [8:0] tw, pat, exp_rx;
      logic       exp_bit;
      repeat (3) @(negedge clk);
      chk("R1 sda_oe in reset", {8'd0, sda_oe}, 9'd0);
      chk("R1 rx_word in reset", rx_word, 9'd0);
      chk("R1 byte_done in reset", {8'd0, byte_done}, 9'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 sda_oe after reset", {8'd0, sda_oe}, 9'd0);
      chk("R1 byte_done after reset", {8'd0, byte_done}, 9'd0);

      for (int v = 0; v < 7; v++) begin
         tw        = VEC[v][28:20];
         pat       = VEC[v][19:11];
         alt_pack  = VEC[v][10];
         clk_phase = VEC[v][9];
         exp_rx    = VEC[v][8:0];
         tx_word   = tw;
         @(negedge clk) load = 1'b1;
         @(negedge clk) load = 1'b0;
         for (int k = 0; k < 9; k++) begin
            exp_bit = (k < 8) ? tw[7-k] : tw[8];
            chk($sformatf("R2 R3 vec%0d tx bit%0d", v, k), {8'd0, sda_oe}, {8'd0, !exp_bit});
            sda_in = pat[8-k];
            pulse_rise();
            if (k == 8) begin
               chk($sformatf("R7 vec%0d done", v), {8'd0, byte_done}, 9'd1);
               chk($sformatf("R8 R9 R10 vec%0d rx_word", v), rx_word, exp_rx);
               chk($sformatf("R3 vec%0d ack held", v), {8'd0, sda_oe}, {8'd0, !tw[8]});
               @(negedge clk);
               chk($sformatf("R7 vec%0d done single", v), {8'd0, byte_done}, 9'd0);
            end else begin
               chk($sformatf("R7 vec%0d no early done", v), {8'd0, byte_done}, 9'd0);
            end
            pulse_fall();
         end
         chk($sformatf("R3 vec%0d idle released", v), {8'd0, sda_oe}, 9'd0);
         chk($sformatf("R7 vec%0d rx held", v), rx_word, exp_rx);
      end

      // R6 R3: preset resting level low while channel off
      chan_en  = 1'b0;
      idle_lvl = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R6 R3 preset low drives line", {8'd0, sda_oe}, 9'd1);

      // R5: force release is immediate
      @(negedge clk) sda_off = 1'b1;
      #1 chk("R5 forced release", {8'd0, sda_oe}, 9'd0);
      @(negedge clk) sda_off = 1'b0;
      #1 chk("R5 release removed", {8'd0, sda_oe}, 9'd1);

      // R6: load ignored while channel off
      tx_word = 9'h1FF;
      @(negedge clk) load = 1'b1;
      @(negedge clk) load = 1'b0;
      pulse_fall();
      @(negedge clk);
      chk("R6 load ignored when off", {8'd0, sda_oe}, 9'd1);

      // R6: preset ignored while channel on
      chan_en = 1'b1;
      @(negedge clk) idle_lvl = 1'b1;
      repeat (3) @(negedge clk);
      chk("R6 preset ignored when on", {8'd0, sda_oe}, 9'd1);

      // R4: delay select 3 gives four clocks
      repeat (10) @(negedge clk);
      dly_sel  = 3'd3;
      chan_en  = 1'b0;
      idle_lvl = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk($sformatf("R4 delay4 hold cycle%0d", i), {8'd0, sda_oe}, 9'd1);
      end
      @(negedge clk);
      chk("R4 delay4 edge", {8'd0, sda_oe}, 9'd0);

      // R4: delay select 7 gives eight clocks
      repeat (10) @(negedge clk);
      dly_sel  = 3'd7;
      idle_lvl = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk($sformatf("R4 delay8 hold cycle%0d", i), {8'd0, sda_oe}, 9'd0);
      end
      @(negedge clk);
      chk("R4 delay8 edge", {8'd0, sda_oe}, 9'd1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule